// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides when a small 4-bit processor core may break into an interrupt routine. Each source raises a one-clock request pulse, which latches into a pending flag. A pending flag that is not masked can start interrupt entry when four things are true: the master enable is set, the core signals an instruction boundary, that boundary ends a complete instruction, and no skip run is in progress. Entry is a one-clock strobe. During that strobe the block tells the core to push the program counter, and it presents the fixed vector address of the winning source. At the same edge it clears the master enable and the winning pending flag.

A return-from-interrupt executed by the core sets the master enable again. A pending request is never accepted at the boundary of the return itself. The instruction at the return address always runs to completion first, and that includes both words of a two-word instruction. Any remaining request is then taken in priority order. Source 0 has the highest priority and source NSRC-1 the lowest.

Top module: `irq_entry_seq`

## Requirements
- R1: When reset is released, `int_o` and `push_pc_o` are 0, `ime_o` equals parameter `IME_AT_RESET` (default 1), and no source is pending.
- R2: A pulse on `req_i[k]` sets pending flag k at the next clock. Suppose that at a clock where `cyc_end_i`=1 the entry conditions hold: master enable set, a pending unmasked source, `busy_i`=0, `skip_i`=0 and `rtni_i`=0. Then `int_o` and `push_pc_o` are 1 for exactly the next clock cycle, and `vec_o` holds `VECTORS[k]` for the selected source k.
- R3: The cycle in which `int_o` is 1 already shows `ime_o`=0, and no further entry happens until a return sets the enable again.
- R4: When several unmasked sources are pending, the lowest index is served.
- R5: A source with `mask_i[k]`=1 never causes entry. Its pending flag stays set, and entry follows once the mask bit returns to 0.
- R6: While `ime_o`=0, requests still latch as pending, and they are served after the enable is set again.
- R7: `rtni_i`=1 at a boundary sets `ime_o` at the next clock. No entry is made at that boundary. Entry can happen at the next boundary that completes an instruction.
- R8: No entry occurs at a boundary with `busy_i`=1, which marks an unfinished two-cycle or two-word instruction.
- R9: No entry occurs at a boundary with `skip_i`=1, which means a skip run, including a chain of skipped load-immediate instructions, continues.
- R10: Entry clears the pending flag of the served source. A new request from that source in the same clock keeps the flag set.
- R11: Entry is decided only in clocks with `cyc_end_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NSRC | Per-source request pulses |
| mask_i | input | NSRC | Per-source mask, 1 blocks entry |
| cyc_end_i | input | 1 | Instruction-cycle boundary from the core |
| busy_i | input | 1 | At this boundary the current instruction is not finished |
| skip_i | input | 1 | At this boundary a skip run continues |
| rtni_i | input | 1 | Return-from-interrupt completes at this boundary |
| int_o | output | 1 | Interrupt-processing strobe |
| push_pc_o | output | 1 | Command to push the program counter |
| vec_o | output | VEC_W | Vector address of the accepted source |
| ime_o | output | 1 | Master interrupt enable state |

## Verification
The assertions assume that the core reports `busy_i`, `skip_i` and `rtni_i` only together with `cyc_end_i`. They also assume the core never signals a return and an unfinished instruction at the same boundary. The random stimulus derives all three status inputs from a boundary draw, and it issues a return only while the enable is clear and the boundary completes an instruction. The masks change freely because the design makes no assumption about them.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int IDX_W = 4;

    typedef logic [IDX_W-1:0] src_idx_t;

    typedef struct packed {
        logic     any;
        src_idx_t idx;
    } pick_t;

    function automatic pick_t pick_lowest(input logic [15:0] live, input int n);
        pick_t r;
        r.any = 1'b0;
        r.idx = '0;
        for (int i = 15; i >= 0; i--) begin
            if (i < n && live[i]) begin
                r.any = 1'b1;
                r.idx = src_idx_t'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);
    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) pend_o[g] <= 1'b0;
            else     pend_o[g] <= req_i[g] | (pend_o[g] & ~clr_i[g]);
        end

        AST_REQ_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
            req_i[g] |=> pend_o[g]); // R10
    end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_seq_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] pend_i,
    input  logic [NSRC-1:0] mask_i,
    output pick_t           pick_o,
    output logic [NSRC-1:0] grant_o
);
    logic [15:0] live;

    always_comb begin
        live = '0;
        live[NSRC-1:0] = pend_i & ~mask_i;
        pick_o = pick_lowest(live, NSRC);
        grant_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pick_o.any && pick_o.idx == src_idx_t'(i)) grant_o[i] = 1'b1;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o)); // R4
    AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        (grant_o & mask_i) == '0); // R5
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_seq_pkg::*;
#(
    parameter int                             NSRC         = 4,
    parameter int                             VEC_W        = 12,
    parameter logic [NSRC-1:0][VEC_W-1:0]     VECTORS      = '0,
    parameter bit                             IME_AT_RESET = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cyc_end_i,
    input  logic            busy_i,
    input  logic            skip_i,
    input  logic            rtni_i,
    input  pick_t           pick_i,
    input  logic [NSRC-1:0] grant_i,
    output logic [NSRC-1:0] clr_o,
    output logic            int_o,
    output logic [VEC_W-1:0] vec_o,
    output logic            ime_o
);
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic take;

    assign take  = cyc_end_i && ime_o && !busy_i && !skip_i && !rtni_i && pick_i.any;
    assign clr_o = take ? grant_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            int_o <= 1'b0;
            vec_o <= '0;
            ime_o <= IME_AT_RESET;
        end else begin
            int_o <= take;
            if (take) begin
                vec_o <= VECTORS[pick_i.idx[SEL_W-1:0]];
                ime_o <= 1'b0;
            end else if (cyc_end_i && rtni_i) begin
                ime_o <= 1'b1;
            end
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        int_o |=> !int_o); // R2
    AST_ENTRY_DISABLES: assert property (@(posedge clk) disable iff (rst)
        int_o |-> !ime_o); // R3
    AST_ENTRY_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        int_o |-> $past(cyc_end_i)); // R11
    AST_NO_ENTRY_BUSY: assert property (@(posedge clk) disable iff (rst)
        int_o |-> !$past(busy_i)); // R8
    AST_NO_ENTRY_SKIP: assert property (@(posedge clk) disable iff (rst)
        int_o |-> !$past(skip_i)); // R9
    AST_RETURN_ENABLES: assert property (@(posedge clk) disable iff (rst)
        (cyc_end_i && rtni_i) |=> (ime_o && !int_o)); // R7
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
    parameter int                         NSRC         = 4,
    parameter int                         VEC_W        = 12,
    parameter logic [NSRC-1:0][VEC_W-1:0] VECTORS      = {12'h01C, 12'h014, 12'h00C, 12'h004},
    parameter bit                         IME_AT_RESET = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  req_i,
    input  logic [NSRC-1:0]  mask_i,
    input  logic             cyc_end_i,
    input  logic             busy_i,
    input  logic             skip_i,
    input  logic             rtni_i,
    output logic             int_o,
    output logic             push_pc_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             ime_o
);
    import irq_seq_pkg::*;

    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] grant;
    logic [NSRC-1:0] clr;
    pick_t           pick;

    irq_pend_bank #(.NSRC(NSRC)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irq_prio_sel #(.NSRC(NSRC)) u_prio (
        .clk     (clk),
        .rst     (rst),
        .pend_i  (pend),
        .mask_i  (mask_i),
        .pick_o  (pick),
        .grant_o (grant)
    );

    irq_entry_ctrl #(
        .NSRC         (NSRC),
        .VEC_W        (VEC_W),
        .VECTORS      (VECTORS),
        .IME_AT_RESET (IME_AT_RESET)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cyc_end_i (cyc_end_i),
        .busy_i    (busy_i),
        .skip_i    (skip_i),
        .rtni_i    (rtni_i),
        .pick_i    (pick),
        .grant_i   (grant),
        .clr_o     (clr),
        .int_o     (int_o),
        .vec_o     (vec_o),
        .ime_o     (ime_o)
    );

    assign push_pc_o = int_o;

    AST_PUSH_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(int_o) |-> (push_pc_o && !ime_o)); // R3
endmodule

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
    localparam logic [3:0][11:0] BV = {12'h01C, 12'h014, 12'h00C, 12'h004};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] req_i = '0, mask_i = '0;
    logic cyc_end_i = 1'b0, busy_i = 1'b0, skip_i = 1'b0, rtni_i = 1'b0;
    logic int_o, push_pc_o, ime_o;
    logic [11:0] vec_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [3:0]  m_pend = '0;
    logic        m_int = 1'b0, m_ime = 1'b1;
    logic [11:0] m_vec = '0;

    always #4 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst(rst), .req_i(req_i), .mask_i(mask_i),
        .cyc_end_i(cyc_end_i), .busy_i(busy_i), .skip_i(skip_i), .rtni_i(rtni_i),
        .int_o(int_o), .push_pc_o(push_pc_o), .vec_o(vec_o), .ime_o(ime_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int lowest(input logic [3:0] v);
        for (int i = 0; i < 4; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic step(input logic [3:0] rq, input logic [3:0] mk, input bit cy,
                        input bit bz, input bit sk, input bit rt, input string tag);
        logic [3:0] clr;
        bit take;
        int s;
        req_i = rq; mask_i = mk; cyc_end_i = cy; busy_i = bz; skip_i = sk; rtni_i = rt;
        s = lowest(m_pend & ~mk);
        take = cy && m_ime && !bz && !sk && !rt && (s >= 0);
        clr = '0;
        m_int = take;
        if (take) begin
            clr[s] = 1'b1;
            m_vec = BV[s];
            m_ime = 1'b0;
        end else if (cy && rt) begin
            m_ime = 1'b1;
        end
        m_pend = rq | (m_pend & ~clr);
        @(posedge clk);
        @(negedge clk);
        chk(int_o === m_int, tag, "int_o", 32'(int_o), 32'(m_int));
        chk(push_pc_o === m_int, tag, "push_pc_o", 32'(push_pc_o), 32'(m_int));
        chk(ime_o === m_ime, tag, "ime_o", 32'(ime_o), 32'(m_ime));
        if (m_int) chk(vec_o === m_vec, tag, "vec_o", 32'(vec_o), 32'(m_vec));
    endtask

    task automatic idle(input string tag);
        step(4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic ret(input string tag);
        step(4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b1, tag);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(int_o === 1'b0, "R1", "int_o", 32'(int_o), 0);
        chk(push_pc_o === 1'b0, "R1", "push_pc_o", 32'(push_pc_o), 0);
        chk(ime_o === 1'b1, "R1", "ime_o", 32'(ime_o), 1);
        idle("R1");

        // R2 single source, R3 enable dropped
        step(4'b0100, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        idle("R2");
        idle("R3");
        ret("R7");

        // R11 no decision without a boundary
        step(4'b0001, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
        step(4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
        idle("R11");
        ret("R7");

        // R4 priority, R7 return then one full instruction, R8 two-word
        step(4'b1010, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        idle("R4");
        ret("R7");
        step(4'h0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        idle("R7");
        ret("R7");

        // R9 skip chain
        step(4'b0010, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        step(4'h0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
        step(4'h0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
        idle("R9");
        ret("R7");

        // R5 mask holds a source back
        step(4'b0001, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        step(4'h0, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        step(4'h0, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        idle("R5");
        // R6 requests latch while disabled
        step(4'b1000, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        idle("R6");
        ret("R6");
        idle("R6");
        ret("R7");

        // R10 same-clock request keeps the flag
        step(4'b0100, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
        step(4'b0100, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
        ret("R10");
        idle("R10");
        ret("R10");
        idle("R10");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] rq, mk;
            bit cy, bz, sk, rt;
            rq = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
            mk = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
            cy = ($urandom % 3) != 0;
            bz = cy && ($urandom % 4 == 0);
            sk = cy && !bz && ($urandom % 5 == 0);
            rt = cy && !bz && !sk && !m_ime && ($urandom % 3 == 0);
            step(rq, mk, cy, bz, sk, rt, "R2");
        end
        finish_run();
    end
endmodule